// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of an 8-bit processor whose low address byte and data byte share one set of pins. The core hands it one request at a time: a cycle kind, a 16-bit address, the data to write and, for opcode fetches, a flag that selects the long fetch. The sequencer then steps through its T-states. It drives the upper address byte and the shared address/data byte. It pulses an address-latch strobe so that external logic can catch the low address. It presents three status lines early enough to act as device selects, and it asserts one active-low command strobe (read, write or interrupt acknowledge) for the data transfer. When the final T-state is reached it raises a one-cycle done pulse. For reads, the byte on the shared bus is captured as the read strobe ends.

Two inputs can stretch the cycle or the time between cycles. A low ready input inserts wait states. A high hold input makes the sequencer release every driven bus pin and acknowledge once the current cycle has finished. Instead of tri-state pins the block has explicit drive-enable outputs, so that the pad ring does the tri-stating.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset and while idle: the address-latch strobe is low, all three command strobes are high, status {io_m,s1,s0} is 000, no drive enable is high, done is low and the hold acknowledge is low.
- R2: req_type codes: 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge. The matching status {io_m,s1,s0} values are 011, 010, 001, 110, 101 and 111. The status is valid from T1 and stays constant until the final T-state.
- R3: The address-latch strobe is high for exactly the T1 state. In T1 the shared byte carries address bits 7:0 with its drive enable high, and the high byte carries address bits 15:8. No command strobe is low while the latch strobe is high.
- R4: In I/O read and I/O write cycles, address bits 7:0 (the port number) appear on both the high byte and the shared byte during T1.
- R5: With ready held high, memory, I/O and interrupt-acknowledge cycles take 3 T-states. An opcode fetch takes 4 T-states when req_long is 0 and 6 when it is 1. The count runs from the T1 state to the done state, inclusive.
- R6: The command strobe is low from T2 through T3, wait states included. rd_n is used for fetch and reads, wr_n for writes and inta_n for interrupt acknowledge. Write cycles drive the write data on the shared byte from T2 onward. Read and acknowledge cycles release the shared byte from T2.
- R7: ready is sampled at the end of T2 and of each wait state. Each sample taken low adds one wait state.
- R8: The byte on ad_in is captured into rd_data at the clock edge that ends T3 of a fetch, read or acknowledge cycle. rd_data then holds until the next such capture.
- R9: done is high for exactly the final T-state of each cycle.
- R10: hold is only acted on between cycles. A hold raised during a cycle does not shorten it. hlda rises in the cycle after done and stays high while hold is high. During hold both address drive enables are low, and requests are ignored.
- R11: A request with req_type 6 or 7, or one made while a cycle or hold is in progress, starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_type | input | 3 | Cycle kind code |
| req_long | input | 1 | Selects the 6-state opcode fetch |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Data for write cycles |
| ready | input | 1 | Low inserts wait states |
| hold | input | 1 | Bus release request |
| ad_in | input | 8 | Shared byte as seen from the pins |
| ad_out | output | 8 | Shared byte drive value |
| ad_oe | output | 1 | Shared byte drive enable |
| a_hi | output | 8 | High address byte |
| a_hi_oe | output | 1 | High byte drive enable |
| ale | output | 1 | Address-latch strobe |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| inta_n | output | 1 | Active-low interrupt-acknowledge strobe |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | High in the final T-state |
| hlda | output | 1 | Hold acknowledge |

## Verification
Two events can fall on the same clock edge: completion of a cycle (the done state) and acceptance of a hold request. The bench raises hold in T2 of a write cycle, and again in an I/O read that is also stretched by wait states. It then expects the full T-state count, the done pulse at the usual position and a correctly captured read byte, with hlda high and every bus drive released in the very next cycle. Wait insertion and the read capture are also made to coincide: the capture edge must still be the one that ends T3, after all the waits.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam logic [2:0] CYC_FETCH = 3'd0;
    localparam logic [2:0] CYC_MRD   = 3'd1;
    localparam logic [2:0] CYC_MWR   = 3'd2;
    localparam logic [2:0] CYC_IORD  = 3'd3;
    localparam logic [2:0] CYC_IOWR  = 3'd4;
    localparam logic [2:0] CYC_INTA  = 3'd5;

    // ten T-states the sequencer can occupy
    typedef enum logic [3:0] {
        TS_RST  = 4'd0,
        TS_IDLE = 4'd1,
        TS_T1   = 4'd2,
        TS_T2   = 4'd3,
        TS_TW   = 4'd4,
        TS_T3   = 4'd5,
        TS_T4   = 4'd6,
        TS_T5   = 4'd7,
        TS_T6   = 4'd8,
        TS_HOLD = 4'd9
    } tstate_e;

    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
        logic rd;     // uses the read strobe
        logic wr;     // uses the write strobe
        logic ack;    // uses the acknowledge strobe
        logic fetch;  // opcode fetch, 4 or 6 states
        logic port;   // mirror port number onto high byte
    } cyc_attr_t;

endpackage

// File: rtl/mbs_decode.sv
module mbs_decode
    import mbs_pkg::*;
(
    input  logic [2:0] typ,
    output cyc_attr_t  attr,
    output logic       legal
);
    always_comb begin
        attr  = '0;
        legal = 1'b1;
        case (typ)
            CYC_FETCH: begin attr.s1 = 1'b1; attr.s0 = 1'b1; attr.rd = 1'b1; attr.fetch = 1'b1; end
            CYC_MRD:   begin attr.s1 = 1'b1; attr.rd = 1'b1; end
            CYC_MWR:   begin attr.s0 = 1'b1; attr.wr = 1'b1; end
            CYC_IORD:  begin attr.io_m = 1'b1; attr.s1 = 1'b1; attr.rd = 1'b1; attr.port = 1'b1; end
            CYC_IOWR:  begin attr.io_m = 1'b1; attr.s0 = 1'b1; attr.wr = 1'b1; attr.port = 1'b1; end
            CYC_INTA:  begin attr.io_m = 1'b1; attr.s1 = 1'b1; attr.s0 = 1'b1; attr.ack = 1'b1; end
            default:   legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_legal,
    input  cyc_attr_t         req_attr,
    input  logic              req_long,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic              hold,
    input  logic [DATA_W-1:0] ad_in,
    output tstate_e           st,
    output cyc_attr_t         attr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);
    typedef struct packed {
        tstate_e           st;
        cyc_attr_t         attr;
        logic              lng;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdat;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_d;

    always_comb begin
        seq_d  = seq_q;
        last_d = 1'b0;
        unique case (seq_q.st)
            TS_RST:  seq_d.st = TS_IDLE;
            TS_IDLE: begin
                if (hold) begin
                    seq_d.st = TS_HOLD;
                end else if (req_valid && req_legal) begin
                    seq_d.st    = TS_T1;
                    seq_d.attr  = req_attr;
                    seq_d.lng   = req_long;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                end
            end
            TS_T1:   seq_d.st = TS_T2;
            TS_T2, TS_TW: seq_d.st = ready ? TS_T3 : TS_TW;
            TS_T3: begin
                if (seq_q.attr.rd || seq_q.attr.ack) seq_d.rdat = ad_in;
                if (seq_q.attr.fetch) begin
                    seq_d.st = TS_T4;
                end else begin
                    last_d   = 1'b1;
                    seq_d.st = hold ? TS_HOLD : TS_IDLE;
                end
            end
            TS_T4: begin
                if (seq_q.lng) begin
                    seq_d.st = TS_T5;
                end else begin
                    last_d   = 1'b1;
                    seq_d.st = hold ? TS_HOLD : TS_IDLE;
                end
            end
            TS_T5:   seq_d.st = TS_T6;
            TS_T6: begin
                last_d   = 1'b1;
                seq_d.st = hold ? TS_HOLD : TS_IDLE;
            end
            TS_HOLD: seq_d.st = hold ? TS_HOLD : TS_IDLE;
            default: seq_d.st = TS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= TS_RST;
            seq_q.attr  <= '0;
            seq_q.lng   <= 1'b0;
            seq_q.addr  <= '0;
            seq_q.wdata <= '0;
            seq_q.rdat  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st      = seq_q.st;
    assign attr    = seq_q.attr;
    assign addr    = seq_q.addr;
    assign wdata   = seq_q.wdata;
    assign rd_data = seq_q.rdat;
    assign done    = last_d;

    // R7
    wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == TS_T2 && !ready) |=> (seq_q.st == TS_TW));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == TS_HOLD && !hold) |=> (seq_q.st == TS_IDLE));

    // R8
    rdata_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != TS_T3) |=> $stable(rd_data));
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tstate_e           st,
    input  cyc_attr_t         attr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              a_hi_oe,
    output logic              ale,
    output logic              io_m,
    output logic              s1,
    output logic              s0,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              hlda
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic in_cyc, xfer, addr_ph;

    always_comb begin
        in_cyc  = (st == TS_T1) || (st == TS_T2) || (st == TS_TW) || (st == TS_T3)
               || (st == TS_T4) || (st == TS_T5) || (st == TS_T6);
        xfer    = (st == TS_T2) || (st == TS_TW) || (st == TS_T3);
        addr_ph = (st == TS_T1);

        ale     = addr_ph;
        io_m    = in_cyc & attr.io_m;
        s1      = in_cyc & attr.s1;
        s0      = in_cyc & attr.s0;
        rd_n    = ~(xfer & attr.rd);
        wr_n    = ~(xfer & attr.wr);
        inta_n  = ~(xfer & attr.ack);
        hlda    = (st == TS_HOLD);

        a_hi_oe = in_cyc;
        a_hi    = attr.port ? HI_W'(addr[DATA_W-1:0]) : addr[ADDR_W-1:DATA_W];
        ad_oe   = addr_ph | (xfer & attr.wr);
        ad_out  = addr_ph ? addr[DATA_W-1:0] : wdata;
    end

    // R3
    ale_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && inta_n));

    // R6
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

    // R6
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    // R10
    hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> !(ad_oe || a_hi_oe));

    // R2
    status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && a_hi_oe && $past(a_hi_oe)) |-> $stable({io_m, s1, s0}));
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_type,
    input  logic                     req_long,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     ready,
    input  logic                     hold,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     a_hi_oe,
    output logic                     ale,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     inta_n,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     done,
    output logic                     hlda
);
    cyc_attr_t         dec_attr, cur_attr;
    logic              dec_legal;
    tstate_e           cur_st;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    mbs_decode u_decode (
        .typ   (req_type),
        .attr  (dec_attr),
        .legal (dec_legal)
    );

    mbs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_legal (dec_legal),
        .req_attr  (dec_attr),
        .req_long  (req_long),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .hold      (hold),
        .ad_in     (ad_in),
        .st        (cur_st),
        .attr      (cur_attr),
        .addr      (cur_addr),
        .wdata     (cur_wdata),
        .rd_data   (rd_data),
        .done      (done)
    );

    mbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (cur_st),
        .attr    (cur_attr),
        .addr    (cur_addr),
        .wdata   (cur_wdata),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .a_hi    (a_hi),
        .a_hi_oe (a_hi_oe),
        .ale     (ale),
        .io_m    (io_m),
        .s1      (s1),
        .s0      (s0),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .inta_n  (inta_n),
        .hlda    (hlda)
    );

    // R9
    done_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> !done);

    // R10
    hlda_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (rd_n && wr_n && inta_n && !ale));
endmodule

// File: tb/mbus_cycle_seq_tb.sv
module mbus_cycle_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_type = 3'd0;
    logic        req_long = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic [7:0]  ad_in = 8'h0;
    logic [7:0]  ad_out, a_hi, rd_data;
    logic        ad_oe, a_hi_oe, ale, io_m, s1, s0, rd_n, wr_n, inta_n, done, hlda;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    mbus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .hold(hold), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .a_hi_oe(a_hi_oe), .ale(ale), .io_m(io_m), .s1(s1), .s0(s0),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .rd_data(rd_data), .done(done),
        .hlda(hlda)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_status(input logic [2:0] t);
        case (t)
            3'd0: return 3'b011;
            3'd1: return 3'b010;
            3'd2: return 3'b001;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            3'd5: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    // one full cycle with optional waits and a hold raised in T2
    task automatic run_cycle(input logic [2:0] t, input logic lng, input logic [15:0] a,
                             input logic [7:0] wd, input logic [7:0] rv,
                             input int nwait, input logic hold_mid);
        int exp_len;
        int k;
        int done_k;
        int cmd_cnt;
        int bad_ale, bad_stat, bad_bus;
        logic got;
        logic is_rd, is_wr, is_ack;
        is_rd  = (t == 3'd0) || (t == 3'd1) || (t == 3'd3);
        is_wr  = (t == 3'd2) || (t == 3'd4);
        is_ack = (t == 3'd5);
        exp_len = ((t == 3'd0) ? (lng ? 6 : 4) : 3) + nwait;
        @(negedge clk);
        req_type = t; req_long = lng; req_addr = a; req_wdata = wd;
        ad_in = rv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1; got = 1'b0; done_k = 0; cmd_cnt = 0;
        bad_ale = 0; bad_stat = 0; bad_bus = 0;
        while (!got && k < 40) begin
            if (k == 1) begin
                chk("R3 ale in T1", {31'd0, ale}, 32'd1);
                chk("R3 low addr on shared byte", {23'd0, ad_oe, ad_out}, {23'd0, 1'b1, a[7:0]});
                chk("R2 status in T1", {29'd0, io_m, s1, s0}, {29'd0, exp_status(t)});
                if (t == 3'd3 || t == 3'd4)
                    chk("R4 port mirrored", {24'd0, a_hi}, {24'd0, a[7:0]});
                else
                    chk("R3 high addr byte", {24'd0, a_hi}, {24'd0, a[15:8]});
            end else if (ale) begin
                bad_ale++;
            end
            if ({io_m, s1, s0} != exp_status(t)) bad_stat++;
            if ((is_rd && !rd_n) || (is_wr && !wr_n) || (is_ack && !inta_n)) cmd_cnt++;
            if (!is_rd && !rd_n) bad_bus++;
            if (!is_wr && !wr_n) bad_bus++;
            if (!is_ack && !inta_n) bad_bus++;
            if (is_wr && k >= 2 && k <= 3 + nwait && !(ad_oe && ad_out == wd)) bad_bus++;
            if (!is_wr && k >= 2 && ad_oe) bad_bus++;
            if (done) begin got = 1'b1; done_k = k; end
            ready = !(k >= 2 && k <= 1 + nwait);
            hold  = hold_mid && (k >= 2);
            if (!got) begin
                @(negedge clk);
                k++;
            end
        end
        ready = 1'b1;
        chk("R5 R7 T-state count", done_k, exp_len);
        chk("R3 ale only in T1", bad_ale, 0);
        chk("R2 status constant", bad_stat, 0);
        chk("R6 strobe low cycles", cmd_cnt, 2 + nwait);
        chk("R6 strobe kind and bus drive", bad_bus, 0);
        @(negedge clk);
        chk("R9 done one cycle", {31'd0, done}, 32'd0);
        if (is_rd || is_ack) chk("R8 read byte captured", {24'd0, rd_data}, {24'd0, rv});
        if (hold_mid) begin
            chk("R10 hlda right after done", {31'd0, hlda}, 32'd1);
            chk("R10 bus released", {30'd0, ad_oe, a_hi_oe}, 32'd0);
            hold = 1'b0;
            @(negedge clk);
            chk("R10 hlda drops", {31'd0, hlda}, 32'd0);
        end else begin
            chk("R1 idle after cycle", {28'd0, ale, rd_n, wr_n, inta_n}, 32'h7);
        end
        ad_in = ~rv;
        @(negedge clk);
        if (is_rd || is_ack) chk("R8 read byte held", {24'd0, rd_data}, {24'd0, rv});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset strobes", {29'd0, rd_n, wr_n, inta_n}, 32'h7);
        chk("R1 reset status", {29'd0, io_m, s1, s0}, 32'h0);
        chk("R1 reset drives", {27'd0, ale, ad_oe, a_hi_oe, done, hlda}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {27'd0, ale, ad_oe, a_hi_oe, done, hlda}, 32'h0);
    endtask

    task automatic t_illegal();
        int seen;
        seen = 0;
        @(negedge clk);
        req_type = 3'd6; req_valid = 1'b1;
        @(negedge clk);
        req_type = 3'd7;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (ale || a_hi_oe || !rd_n || !wr_n || !inta_n) seen++;
            @(negedge clk);
        end
        chk("R11 codes 6 and 7 start nothing", seen, 0);
    endtask

    task automatic t_busy_request();
        int seen;
        seen = 0;
        @(negedge clk);
        req_type = 3'd1; req_addr = 16'h1234; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 16'hBEEF;          // T1: keep asking
        @(negedge clk);
        req_valid = 1'b0;             // T2: dropped before cycle ends
        for (int i = 0; i < 5; i++) begin
            if (ale) seen++;
            @(negedge clk);
        end
        chk("R11 request during cycle ignored", seen, 0);
    endtask

    task automatic t_hold_idle();
        int seen;
        seen = 0;
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        chk("R10 hlda from idle", {31'd0, hlda}, 32'd1);
        chk("R10 idle hold released bus", {30'd0, ad_oe, a_hi_oe}, 32'd0);
        req_type = 3'd2; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (ale || a_hi_oe) seen++;
        @(negedge clk);
        if (ale || a_hi_oe) seen++;
        hold = 1'b0;
        @(negedge clk);
        chk("R10 hlda low after release", {31'd0, hlda}, 32'd0);
        for (int i = 0; i < 3; i++) begin
            if (ale) seen++;
            @(negedge clk);
        end
        chk("R11 request in hold ignored", seen, 0);
    endtask

    initial begin
        t_reset();
        run_cycle(3'd0, 1'b0, 16'h8001, 8'h00, 8'h3E, 0, 1'b0);
        run_cycle(3'd0, 1'b1, 16'h4C22, 8'h00, 8'hC3, 0, 1'b0);
        run_cycle(3'd1, 1'b0, 16'hA55A, 8'h00, 8'h96, 0, 1'b0);
        run_cycle(3'd2, 1'b0, 16'h1F80, 8'h5C, 8'h00, 0, 1'b0);
        run_cycle(3'd3, 1'b0, 16'h0071, 8'h00, 8'hE4, 0, 1'b0);
        run_cycle(3'd4, 1'b0, 16'h00C8, 8'hA7, 8'h00, 0, 1'b0);
        run_cycle(3'd5, 1'b0, 16'h7FFE, 8'h00, 8'hFF, 0, 1'b0);
        run_cycle(3'd1, 1'b0, 16'h0100, 8'h00, 8'h42, 2, 1'b0);
        run_cycle(3'd0, 1'b1, 16'hFFFF, 8'h00, 8'h18, 1, 1'b0);
        run_cycle(3'd2, 1'b0, 16'h2468, 8'h81, 8'h00, 0, 1'b1);
        run_cycle(3'd3, 1'b0, 16'h00AB, 8'h00, 8'h6D, 3, 1'b1);
        t_illegal();
        t_busy_request();
        t_hold_idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule